// File: doc/BRIEF.md
# Dual-mode print head line decoder

This block turns a short binary code and a set of active-low bank strobes into a 28-bit vector of print head firing lines. A static layout pin, read only while the block is held in reset, chooses one of two arrangements. In the wide layout, a 4-bit code selects one of 14 positions. Each of two banks fires the line at that position. In the narrow layout, a 3-bit code selects one of 7 positions and there are four banks. The input that carries the top code bit in the wide layout becomes the strobe of the third bank. The banks are mirror-indexed: a position k fires a line counted from the bottom of the vector in some banks and from the top in others.

All lines are held off while chip enable is low. They are also held off for a fixed number of clock cycles after reset, which covers supply settling. The code is captured when a strobe falls, so the code may change freely while a strobe is held low. The line vector is registered, so it cannot glitch when the code and the strobes change in the same cycle.

Top module: `print_line_decoder`

## Requirements
- R1: With the wide layout (layout pin sampled as 1), the code is {dual_i, code_i} with code_i[0] as the least significant bit. For k from 0 to 13, strobe fire_n_i[0] low turns on line k, and fire_n_i[1] low turns on line 27-k. In this layout fire_n_i[2] has no effect.
- R2: With the wide layout, codes 14 and 15 leave all lines off whatever the strobes are.
- R3: With the narrow layout (layout pin sampled as 0), only code_i[2:0] selects k, and dual_i acts as an active-low strobe. For k from 0 to 6, fire_n_i[0] low turns on line k, fire_n_i[1] low turns on line 7+k, dual_i low turns on line 27-k, and fire_n_i[2] low turns on line 20-k.
- R4: With the narrow layout, code 7 leaves all lines off.
- R5: A bank whose strobe is high has all of its lines off. With every strobe high, the whole vector is zero.
- R6: While chip_en_i is low, all lines are off from the next clock edge onward. When chip_en_i returns high, the held selection reappears.
- R7: All lines stay off while rst_n is low and for at least LOCK_CYCLES clock cycles after rst_n is released.
- R8: The code is captured in the cycle in which any strobe falls. A change of the code while a strobe stays low does not change the lines.
- R9: Inputs sampled at one clock edge show on lines_o just after that same edge. There is no combinational path from the inputs to lines_o.
- R10: The layout pin is sampled only while reset is active. Changing it afterwards has no effect until the next reset.
- R11: In either layout, at most one line of each bank is on at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Layout pin: 1 = two banks of 14, 0 = four banks of 7; sampled in reset |
| chip_en_i | input | 1 | Active-high chip enable |
| code_i | input | 3 | Low code bits, bit 0 least significant |
| dual_i | input | 1 | Code bit 3 in the wide layout, third bank strobe (active low) in the narrow layout |
| fire_n_i | input | 3 | Active-low strobes of bank one, bank two and the fourth bank |
| lines_o | output | 28 | Registered firing lines |

## Verification
The bench keeps the default bank size of 7 and shortens LOCK_CYCLES to 8. With these values the lockout window can be checked cycle by cycle. The bench then sweeps every combination of code and strobe in both layouts: all 16 codes against both bank strobes in the wide layout, and all 8 codes against all 16 strobe patterns in the narrow layout. The sweeps cover the mirrored indices, the unused codes and the single-line-per-bank property. Directed steps cover the following cases:
- a code change while a strobe is held low;
- a chip enable drop and its release;
- a change of the layout pin after reset, which must leave the layout unchanged.

// File: rtl/print_line_pkg.sv
package print_line_pkg;
  typedef enum logic {
    LAYOUT_NARROW = 1'b0,
    LAYOUT_WIDE   = 1'b1
  } layout_e;

  localparam int STRB_BANK1 = 0;
  localparam int STRB_BANK2 = 1;
  localparam int STRB_BANK3 = 2;
  localparam int STRB_BANK4 = 3;
endpackage

// File: rtl/pld_rst_sync.sv
module pld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/pld_lockout.sv
module pld_lockout #(
  parameter int LOCK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != LIMIT);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pld_strobe_capture.sv
module pld_strobe_capture #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] code_i,
  input  logic [3:0]    strb_n_i,
  output logic [WW-1:0] code_o,
  output logic [3:0]    act_o
);
  logic [3:0]    prev_q;
  logic [WW-1:0] code_q;
  logic          fall;

  always_comb begin
    fall   = |(prev_q & ~strb_n_i);
    code_o = fall ? code_i : code_q;
    act_o  = ~strb_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      code_q <= '0;
    end else begin
      prev_q <= strb_n_i;
      if (fall) code_q <= code_i;
    end
  end
endmodule

// File: rtl/pld_line_map.sv
module pld_line_map
  import print_line_pkg::*;
#(
  parameter int BANK_LINES = 7
) (
  input  logic                    wide_i,
  input  logic [SW:0]             code_i,
  input  logic [3:0]              act_i,
  output logic [4*BANK_LINES-1:0] dec_o
);
  localparam int SW = $clog2(BANK_LINES + 1);
  localparam int WW = SW + 1;
  localparam int B  = BANK_LINES;
  localparam int NL = 4 * BANK_LINES;

  for (genvar i = 0; i < NL; i++) begin : g_line
    localparam int WK = (i < 2*B) ? i : NL - 1 - i;
    localparam int WS = (i < 2*B) ? STRB_BANK1 : STRB_BANK2;
    localparam int SLOT = i / B;
    localparam int NK = (SLOT == 0) ? i :
                        (SLOT == 1) ? i - B :
                        (SLOT == 2) ? 3*B - 1 - i : 4*B - 1 - i;
    localparam int NS = (SLOT == 0) ? STRB_BANK1 :
                        (SLOT == 1) ? STRB_BANK2 :
                        (SLOT == 2) ? STRB_BANK4 : STRB_BANK3;
    assign dec_o[i] = wide_i ? (act_i[WS] && (code_i == WW'(WK)))
                             : (act_i[NS] && (code_i[SW-1:0] == SW'(NK)));
  end
endmodule

// File: rtl/print_line_decoder.sv
module print_line_decoder
  import print_line_pkg::*;
#(
  parameter int BANK_LINES  = 7,
  parameter int LOCK_CYCLES = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_i,
  input  logic                    chip_en_i,
  input  logic [$clog2(BANK_LINES+1)-1:0] code_i,
  input  logic                    dual_i,
  input  logic [2:0]              fire_n_i,
  output logic [4*BANK_LINES-1:0] lines_o
);
  localparam int SW = $clog2(BANK_LINES + 1);
  localparam int WW = SW + 1;
  localparam int NL = 4 * BANK_LINES;

  logic          rst_s_n;
  logic          ready;
  layout_e       mode_q;
  logic          wide;
  logic [3:0]    strb_n;
  logic [WW-1:0] code_full;
  logic [WW-1:0] code_eff;
  logic [3:0]    act;
  logic [NL-1:0] dec;
  logic [NL-1:0] lines_d;
  logic [NL-1:0] lines_q;

  pld_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pld_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ready_o (ready)
  );

  // layout pin is loaded only while the synchronised reset is active
  always_ff @(posedge clk) begin
    if (!rst_s_n) mode_q <= layout_e'(mode_i);
  end

  assign wide = (mode_q == LAYOUT_WIDE);

  always_comb begin
    if (wide) begin
      strb_n    = {1'b1, 1'b1, fire_n_i[1], fire_n_i[0]};
      code_full = {dual_i, code_i};
    end else begin
      strb_n    = {fire_n_i[2], dual_i, fire_n_i[1], fire_n_i[0]};
      code_full = {1'b0, code_i};
    end
  end

  pld_strobe_capture #(.WW(WW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .code_i   (code_full),
    .strb_n_i (strb_n),
    .code_o   (code_eff),
    .act_o    (act)
  );

  pld_line_map #(.BANK_LINES(BANK_LINES)) u_map (
    .wide_i (wide),
    .code_i (code_eff),
    .act_i  (act),
    .dec_o  (dec)
  );

  always_comb lines_d = (ready && chip_en_i) ? dec : '0;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) lines_q <= '0;
    else          lines_q <= lines_d;
  end

  assign lines_o = lines_q;
endmodule

// File: rtl/print_line_decoder_chk.sv
module print_line_decoder_chk #(
  parameter int BANK_LINES  = 7,
  parameter int LOCK_CYCLES = 1000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wide,
  input logic                    chip_en_i,
  input logic                    dual_i,
  input logic [2:0]              fire_n_i,
  input logic [4*BANK_LINES-1:0] lines_o
);
  localparam int B  = BANK_LINES;
  localparam int NL = 4 * BANK_LINES;
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        since_q <= '0;
    else if (since_q != CW'(LOCK_CYCLES)) since_q <= since_q + 1'b1;
  end

  // R7: lines stay dark through the lockout window
  a_r7_lockout_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q != CW'(LOCK_CYCLES)) |-> (lines_o == '0));

  // R6: chip enable low darkens all lines at the next edge
  a_r6_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en_i |=> (lines_o == '0));

  // R5: no active strobe means no active line
  a_r5_idle_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && (&fire_n_i[1:0])) |=> (lines_o == '0));

  a_r5_idle_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && (&fire_n_i) && dual_i) |=> (lines_o == '0));

  // R11: at most one line per bank
  a_r11_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> ($onehot0(lines_o[2*B-1:0]) && $onehot0(lines_o[NL-1:2*B])));

  a_r11_one_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> ($onehot0(lines_o[B-1:0]) && $onehot0(lines_o[2*B-1:B]) &&
               $onehot0(lines_o[3*B-1:2*B]) && $onehot0(lines_o[NL-1:3*B])));

  // R10: layout stays fixed outside reset
  a_r10_layout_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q != '0) |=> $stable(wide));
endmodule

bind print_line_decoder print_line_decoder_chk #(
  .BANK_LINES (BANK_LINES),
  .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wide      (wide),
  .chip_en_i (chip_en_i),
  .dual_i    (dual_i),
  .fire_n_i  (fire_n_i),
  .lines_o   (lines_o)
);

// File: tb/print_line_decoder_tb.sv
module print_line_decoder_tb;
  localparam int B    = 7;
  localparam int LOCK = 8;
  localparam int NL   = 4 * B;

  logic          clk;
  logic          rst_n;
  logic          mode_i;
  logic          chip_en_i;
  logic [2:0]    code_i;
  logic          dual_i;
  logic [2:0]    fire_n_i;
  logic [NL-1:0] lines_o;

  int n_run;
  int n_fail;

  print_line_decoder #(.BANK_LINES(B), .LOCK_CYCLES(LOCK)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .chip_en_i (chip_en_i),
    .code_i    (code_i),
    .dual_i    (dual_i),
    .fire_n_i  (fire_n_i),
    .lines_o   (lines_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [NL-1:0] expect_lines(input bit wide, input int c,
                                                 input logic [3:0] s);
    logic [NL-1:0] e;
    int k;
    e = '0;
    if (wide) begin
      k = c;
      if (k < 2*B) begin
        if (s[0]) e[k] = 1'b1;
        if (s[1]) e[NL-1-k] = 1'b1;
      end
    end else begin
      k = c % 8;
      if (k < B) begin
        if (s[0]) e[k] = 1'b1;
        if (s[1]) e[B+k] = 1'b1;
        if (s[2]) e[NL-1-k] = 1'b1;
        if (s[3]) e[3*B-1-k] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [NL-1:0] exp);
    n_run++;
    if (lines_o !== exp) begin
      n_fail++;
      $display("FAIL %s: lines actual %h expected %h", req, lines_o, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic go_idle();
    @(negedge clk);
    fire_n_i = 3'b111;
    dual_i   = 1'b1;
  endtask

  // wide layout: c is the 4-bit code, s[1:0] the bank strobes
  task automatic drive_wide(input int c, input logic [1:0] s);
    @(negedge clk);
    code_i   = 3'(c);
    dual_i   = c[3];
    fire_n_i = {~c[0], ~s[1], ~s[0]};
  endtask

  task automatic drive_narrow(input int c, input logic [3:0] s);
    @(negedge clk);
    code_i   = 3'(c);
    dual_i   = ~s[2];
    fire_n_i = {~s[3], ~s[1], ~s[0]};
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n     = 1'b0;
    mode_i    = m;
    chip_en_i = 1'b1;
    code_i    = 3'd0;
    dual_i    = 1'b0;
    fire_n_i  = 3'b000;
    repeat (4) @(negedge clk);
    check("R7 in reset", '0);
    rst_n = 1'b1;
    for (int i = 0; i < LOCK; i++) begin
      @(negedge clk);
      check("R7 lockout", '0);
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    mode_i = 1'b1;
    chip_en_i = 1'b0;
    code_i = '0;
    dual_i = 1'b1;
    fire_n_i = 3'b111;

    do_reset(1'b1);

    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 4; s++) begin
        go_idle();
        drive_wide(c, 2'(s));
        @(negedge clk);
        check("R1 R2 R5 R9 wide", expect_lines(1'b1, c, {2'b00, 2'(s)}));
      end
    end

    go_idle();
    drive_wide(3, 2'b01);
    @(negedge clk);
    check("R8 capture", expect_lines(1'b1, 3, 4'b0001));
    @(negedge clk);
    code_i = 3'd5;
    @(negedge clk);
    check("R8 hold low", expect_lines(1'b1, 3, 4'b0001));
    go_idle();
    drive_wide(5, 2'b01);
    @(negedge clk);
    check("R8 recapture", expect_lines(1'b1, 5, 4'b0001));

    chip_en_i = 1'b0;
    @(negedge clk);
    check("R6 enable low", '0);
    chip_en_i = 1'b1;
    @(negedge clk);
    check("R6 enable back", expect_lines(1'b1, 5, 4'b0001));

    mode_i = 1'b0;
    go_idle();
    drive_wide(13, 2'b10);
    @(negedge clk);
    check("R10 pin ignored", expect_lines(1'b1, 13, 4'b0010));
    go_idle();
    drive_wide(2, 2'b01);
    @(negedge clk);
    check("R10 pin ignored dual", expect_lines(1'b1, 2, 4'b0001));

    do_reset(1'b0);
    mode_i = 1'b1;

    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 16; s++) begin
        go_idle();
        drive_narrow(c, 4'(s));
        @(negedge clk);
        check("R3 R4 R5 R11 narrow", expect_lines(1'b0, c, 4'(s)));
      end
    end

    go_idle();
    drive_narrow(4, 4'b0100);
    @(negedge clk);
    check("R3 dual strobe", expect_lines(1'b0, 4, 4'b0100));
    code_i = 3'd1;
    @(negedge clk);
    check("R8 narrow hold", expect_lines(1'b0, 4, 4'b0100));

    go_idle();
    @(negedge clk);
    finish_run();
  end
endmodule